// File: doc/BRIEF.md
# DDR SDRAM Start-Up Sequencer

This block sits on the controller side of a DDR SDRAM command bus. It runs the fixed bring-up sequence once after a synchronous reset. It holds the clock enable low through a long settling wait. It then raises the clock enable with a NOP and issues the following commands in order: a precharge of all banks, an extended mode write that turns the DLL on, a mode write that resets the DLL, and a DLL lock hold. After that come a second precharge of all banks, a programmable number of auto-refresh commands, and the final mode write carrying the operating burst and latency settings. When the last mode-write gap has elapsed it raises a completion flag. The memory controller then takes over the bus.

Every wait is a parameter counted in clock cycles. A command occupies one cycle. The following cycles of its step carry NOP until the step's length has elapsed. The operating burst length, burst type and CAS latency codes are read from input ports in the cycle of the final mode write. The output drive-strength selection is read from an input port in the cycle of the extended mode write.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is asserted, and on the rising edges after release up to and including edge PWR_WAIT_CYC-1, the bus is deselected: cke=0, cs_n=ras_n=cas_n=we_n=1, addr=0, ba=0 and init_done=0.
- R2: The clock enable goes high on the PWR_WAIT_CYC-th rising edge at which reset is sampled low. In that cycle the bus carries a NOP (cs_n=0, ras_n=cas_n=we_n=1). The clock enable then stays high until the next reset.
- R3: The cycle after that NOP carries a precharge of all banks: cs_n=0, ras_n=0, cas_n=1, we_n=0, addr bit 10 = 1, all other address bits 0, ba=0.
- R4: T_RP cycles after the first precharge, an extended mode write is issued: all four command lines low and ba=2'b01. Address bit 0 is 0 (DLL on), address bit 1 equals drive_half (0 full drive, 1 half drive), and all other address bits are 0.
- R5: T_MRD cycles after the extended write, a mode write (all four lines low, ba=2'b00) is issued with only address bit 8 set, which requests a DLL reset.
- R6: The next command, a second precharge of all banks encoded as in R3, is issued exactly DLL_LOCK_CYC cycles after the DLL reset write.
- R7: T_RP cycles after the second precharge, NUM_REF auto-refresh commands are issued (cs_n=0, ras_n=0, cas_n=0, we_n=1, addr=0, ba=0), spaced T_RFC cycles apart.
- R8: T_RFC cycles after the last refresh, a mode write with ba=2'b00 is issued. Its address carries burst_len_code in bits 2..0, burst_interleave in bit 3 and cas_lat_code in bits 6..4. Bits 7 and 8 are 0, and so is every higher bit.
- R9: Every cycle between commands, from the cke-rise cycle onward, carries NOP with addr=0 and ba=0.
- R10: init_done rises exactly T_MRD cycles after the final mode write. It then stays high with NOP on the bus until the next reset.
- R11: Reset asserted at any point of the sequence returns the outputs to the R1 state on the next edge. After release the whole sequence restarts with unchanged timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| burst_len_code | input | 3 | Burst length code placed in address bits 2..0 of the final mode write |
| burst_interleave | input | 1 | Burst type placed in address bit 3 (0 sequential, 1 interleaved) |
| cas_lat_code | input | 3 | CAS latency code placed in address bits 6..4 |
| drive_half | input | 1 | Output drive selection placed in address bit 1 of the extended write |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus |
| ba | output | 2 | Bank address |
| init_done | output | 1 | High once the sequence has completed |

## Verification
Two directed runs use opposite settings on every field: drive strength, burst type, and the extreme legal burst-length and latency codes. These runs show that each input lands in its own address bit and that no bit is swapped or dropped. Further runs draw legal codes at random. About half of them are cut short by a reset at a random cycle, which can fall in the long settling wait, the DLL hold or the refresh train. The run that follows each cut must reproduce the full timing from scratch, so a counter or a refresh tally left stale by the reset shows up as a shifted command. The bench uses three refreshes instead of two, so a refresh count wired to a constant is also caught.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [3:0] {
    ST_PWR_WAIT,
    ST_CKE_UP,
    ST_PREA1,
    ST_EMRS,
    ST_MRS_DLL,
    ST_PREA2,
    ST_REFRESH,
    ST_MRS_RUN,
    ST_DONE
  } init_step_e;

  typedef enum logic [2:0] {
    BUS_DESEL,
    BUS_NOP,
    BUS_PRE,
    BUS_REF,
    BUS_MODE
  } bus_cmd_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_pins_t;

  localparam logic [15:0] PRE_ALL_WORD   = 16'h0400;
  localparam logic [15:0] DLL_RESET_WORD = 16'h0100;
  localparam logic [1:0]  BANK_EXT       = 2'b01;
  localparam logic [1:0]  BANK_MODE      = 2'b00;

  function automatic cmd_pins_t encode_cmd(bus_cmd_e c);
    cmd_pins_t p;
    case (c)
      BUS_NOP:  p = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
      BUS_PRE:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
      BUS_REF:  p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
      BUS_MODE: p = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
      default:  p = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    endcase
    return p;
  endfunction

  // Operating mode word: test bit and DLL-reset bit stay clear.
  function automatic logic [15:0] run_mode_word(logic [2:0] blen, logic btype,
                                                logic [2:0] cl);
    return {7'd0, 1'b0, 1'b0, cl, btype, blen};
  endfunction

  // Extended word: bit0 = 0 turns the DLL on, bit1 picks drive strength.
  function automatic logic [15:0] ext_mode_word(logic half);
    return {14'd0, half, 1'b0};
  endfunction

endpackage

// File: rtl/ddr_init_step_timer.sv
module ddr_init_step_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] len,
  output logic             first,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  assign first = (cnt == '0);
  assign last  = (cnt == len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (last) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // Position inside a step never reaches the step length.
  assert_timer_in_range_R9: assert property (@(posedge clk) disable iff (rst)
    cnt < len);
endmodule

// File: rtl/ddr_init_ref_count.sv
module ddr_init_ref_count #(
  parameter int NUM_REF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bump,
  output logic final_ref
);
  localparam int REF_W = $clog2(NUM_REF + 1);

  logic [REF_W-1:0] done_cnt;

  assign final_ref = (done_cnt == REF_W'(NUM_REF - 1));

  always_ff @(posedge clk) begin
    if (rst)            done_cnt <= '0;
    else if (bump)      done_cnt <= final_ref ? '0 : done_cnt + 1'b1;
  end

  assert_ref_bound_R7: assert property (@(posedge clk) disable iff (rst)
    done_cnt <= REF_W'(NUM_REF - 1));
endmodule

// File: rtl/ddr_init_bus_drive.sv
module ddr_init_bus_drive
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  bus_cmd_e          cmd,
  input  logic [15:0]       word,
  input  logic [1:0]        bank,
  input  logic              cke_on,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        ba
);
  cmd_pins_t pins;

  always_comb begin
    pins  = encode_cmd(cmd);
    cke   = cke_on;
    cs_n  = pins.cs_n;
    ras_n = pins.ras_n;
    cas_n = pins.cas_n;
    we_n  = pins.we_n;
    addr  = (cmd == BUS_PRE || cmd == BUS_MODE) ? ADDR_W'(word) : '0;
    ba    = (cmd == BUS_MODE) ? bank : 2'b00;
  end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int PWR_WAIT_CYC = 33200,
  parameter int T_RP         = 3,
  parameter int T_RFC        = 10,
  parameter int T_MRD        = 2,
  parameter int DLL_LOCK_CYC = 200,
  parameter int NUM_REF      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        burst_len_code,
  input  logic              burst_interleave,
  input  logic [2:0]        cas_lat_code,
  input  logic              drive_half,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [1:0]        ba,
  output logic              init_done
);
  localparam int LEN_A   = (PWR_WAIT_CYC > DLL_LOCK_CYC) ? PWR_WAIT_CYC : DLL_LOCK_CYC;
  localparam int LEN_B   = (T_RFC > T_RP) ? T_RFC : T_RP;
  localparam int LEN_C   = (LEN_B > T_MRD) ? LEN_B : T_MRD;
  localparam int MAX_LEN = (LEN_A > LEN_C) ? LEN_A : LEN_C;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  init_step_e       state, next_state;
  logic [CNT_W-1:0] step_len;
  logic             step_first, step_last, advance, ref_bump, ref_final;
  bus_cmd_e         cmd;
  logic [15:0]      word;
  logic [1:0]       bank;
  logic             cke_on;

  function automatic logic [CNT_W-1:0] len_of(init_step_e s);
    case (s)
      ST_PWR_WAIT: return CNT_W'(PWR_WAIT_CYC);
      ST_PREA1,
      ST_PREA2:    return CNT_W'(T_RP);
      ST_EMRS,
      ST_MRS_RUN:  return CNT_W'(T_MRD);
      ST_MRS_DLL:  return CNT_W'(DLL_LOCK_CYC);
      ST_REFRESH:  return CNT_W'(T_RFC);
      default:     return CNT_W'(1);
    endcase
  endfunction

  assign step_len = len_of(state);
  assign advance  = step_last && (state != ST_DONE);
  assign ref_bump = advance && (state == ST_REFRESH);

  ddr_init_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .len   (step_len),
    .first (step_first),
    .last  (step_last)
  );

  ddr_init_ref_count #(.NUM_REF(NUM_REF)) u_refs (
    .clk       (clk),
    .rst       (rst),
    .bump      (ref_bump),
    .final_ref (ref_final)
  );

  always_comb begin
    next_state = state;
    case (state)
      ST_PWR_WAIT: next_state = ST_CKE_UP;
      ST_CKE_UP:   next_state = ST_PREA1;
      ST_PREA1:    next_state = ST_EMRS;
      ST_EMRS:     next_state = ST_MRS_DLL;
      ST_MRS_DLL:  next_state = ST_PREA2;
      ST_PREA2:    next_state = ST_REFRESH;
      ST_REFRESH:  next_state = ref_final ? ST_MRS_RUN : ST_REFRESH;
      ST_MRS_RUN:  next_state = ST_DONE;
      default:     next_state = ST_DONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          state <= ST_PWR_WAIT;
    else if (advance) state <= next_state;
  end

  always_comb begin
    cmd  = BUS_NOP;
    word = '0;
    bank = BANK_MODE;
    case (state)
      ST_PWR_WAIT: cmd = BUS_DESEL;
      ST_PREA1, ST_PREA2:
        if (step_first) begin cmd = BUS_PRE; word = PRE_ALL_WORD; end
      ST_EMRS:
        if (step_first) begin
          cmd = BUS_MODE; word = ext_mode_word(drive_half); bank = BANK_EXT;
        end
      ST_MRS_DLL:
        if (step_first) begin cmd = BUS_MODE; word = DLL_RESET_WORD; end
      ST_REFRESH:
        if (step_first) cmd = BUS_REF;
      ST_MRS_RUN:
        if (step_first) begin
          cmd  = BUS_MODE;
          word = run_mode_word(burst_len_code, burst_interleave, cas_lat_code);
        end
      default: cmd = BUS_NOP;
    endcase
  end

  assign cke_on    = (state != ST_PWR_WAIT);
  assign init_done = (state == ST_DONE);

  ddr_init_bus_drive #(.ADDR_W(ADDR_W)) u_bus (
    .cmd    (cmd),
    .word   (word),
    .bank   (bank),
    .cke_on (cke_on),
    .cke    (cke),
    .cs_n   (cs_n),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .we_n   (we_n),
    .addr   (addr),
    .ba     (ba)
  );

  // Observation of the driven bus for the spacing checks.
  typedef enum logic [2:0] {LK_NONE, LK_PRE, LK_REF, LK_MODE, LK_DLL} last_kind_e;

  logic       cmd_issue, is_pre, is_ref, is_mode;
  logic [31:0] since_rst, since_cmd;
  last_kind_e last_kind;

  assign cmd_issue = !cs_n && !(ras_n && cas_n && we_n);
  assign is_pre    = cmd_issue && !ras_n &&  cas_n && !we_n;
  assign is_ref    = cmd_issue && !ras_n && !cas_n &&  we_n;
  assign is_mode   = cmd_issue && !ras_n && !cas_n && !we_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= '0;
      since_cmd <= '0;
      last_kind <= LK_NONE;
    end else begin
      if (since_rst != '1) since_rst <= since_rst + 1'b1;
      if (cmd_issue) begin
        since_cmd <= '0;
        if (is_pre)               last_kind <= LK_PRE;
        else if (is_ref)          last_kind <= LK_REF;
        else if (is_mode && addr[8]) last_kind <= LK_DLL;
        else                      last_kind <= LK_MODE;
      end else if (since_cmd != '1) begin
        since_cmd <= since_cmd + 1'b1;
      end
    end
  end

  assert_cke_rise_time_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> since_rst == 32'(PWR_WAIT_CYC));

  assert_cke_hold_R2: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);

  assert_no_cmd_while_cke_low_R1: assert property (@(posedge clk) disable iff (rst)
    !cke |-> cs_n);

  assert_pre_all_banks_R3: assert property (@(posedge clk) disable iff (rst)
    is_pre |-> addr[10]);

  assert_gap_after_pre_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_issue && last_kind == LK_PRE) |-> since_cmd >= 32'(T_RP - 1));

  assert_gap_after_mode_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd_issue && last_kind == LK_MODE) |-> since_cmd >= 32'(T_MRD - 1));

  assert_dll_lock_window_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_issue && last_kind == LK_DLL) |-> since_cmd >= 32'(DLL_LOCK_CYC - 1));

  assert_gap_after_ref_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_issue && last_kind == LK_REF) |-> since_cmd >= 32'(T_RFC - 1));

  assert_mode_bank_high_clear_R8: assert property (@(posedge clk) disable iff (rst)
    is_mode |-> !ba[1]);

  assert_done_hold_R10: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  assert_done_idle_bus_R10: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (cke && !cmd_issue && !cs_n));
endmodule

// File: tb/ddr_init_seq_tb.sv
`timescale 1ns/1ps
module ddr_init_seq_tb;
  localparam int AW   = 12;
  localparam int S    = 24;
  localparam int RP   = 3;
  localparam int MRD  = 2;
  localparam int DLL  = 200;
  localparam int RFC  = 7;
  localparam int NREF = 3;

  localparam int C0 = S + 1;
  localparam int C1 = C0 + RP;
  localparam int C2 = C1 + MRD;
  localparam int C3 = C2 + DLL;
  localparam int C4 = C3 + RP;
  localparam int CF = C4 + NREF * RFC;
  localparam int CD = CF + MRD;
  localparam int LAST = CD + 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] burst_len_code = 3'd1;
  logic       burst_interleave = 1'b0;
  logic [2:0] cas_lat_code = 3'd2;
  logic       drive_half = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [AW-1:0] addr;
  logic [1:0] ba;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ddr_init_seq #(
    .ADDR_W(AW), .PWR_WAIT_CYC(S), .T_RP(RP), .T_RFC(RFC),
    .T_MRD(MRD), .DLL_LOCK_CYC(DLL), .NUM_REF(NREF)
  ) u_dut (
    .clk(clk), .rst(rst),
    .burst_len_code(burst_len_code), .burst_interleave(burst_interleave),
    .cas_lat_code(cas_lat_code), .drive_half(drive_half),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba), .init_done(init_done)
  );

  // Vector layout: {cke, cs_n, ras_n, cas_n, we_n, ba[1:0], addr[11:0], done}
  function automatic logic [19:0] exp_bus(int n, logic [2:0] bl, logic bt,
                                          logic [2:0] cl, logic hf);
    logic c, cs, ra, ca, we, dn;
    logic [1:0] b;
    logic [11:0] a;
    c = 1; cs = 0; ra = 1; ca = 1; we = 1; dn = 0; b = 0; a = 0;
    if (n < S) begin
      c = 0; cs = 1;
    end else if (n == C0 || n == C3) begin
      ra = 0; we = 0; a = 12'h400;
    end else if (n == C1) begin
      ra = 0; ca = 0; we = 0; b = 2'b01; a = {10'd0, hf, 1'b0};
    end else if (n == C2) begin
      ra = 0; ca = 0; we = 0; a = 12'h100;
    end else if (n >= C4 && n < CF && ((n - C4) % RFC) == 0) begin
      ra = 0; ca = 0;
    end else if (n == CF) begin
      ra = 0; ca = 0; we = 0; a = {5'd0, cl, bt, bl};
    end
    if (n >= CD) dn = 1;
    return {c, cs, ra, ca, we, b, a, dn};
  endfunction

  function automatic string tag_of(int n);
    if (n < S)   return "R1";
    if (n == S)  return "R2";
    if (n == C0) return "R3";
    if (n == C1) return "R4";
    if (n == C2) return "R5";
    if (n == C3) return "R6";
    if (n >= C4 && n < CF && ((n - C4) % RFC) == 0) return "R7";
    if (n == CF) return "R8";
    if (n >= CD) return "R10";
    return "R9";
  endfunction

  function automatic logic [19:0] got_bus();
    return {cke, cs_n, ras_n, cas_n, we_n, ba, addr, init_done};
  endfunction

  task automatic check(string tag, int n, logic [19:0] got, logic [19:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s cycle %0d: got %h expected %h", tag, n, got, exp);
    end
  endtask

  task automatic do_run(input logic [2:0] bl, input logic bt, input logic [2:0] cl,
                        input logic hf, input int abort_at);
    burst_len_code   = bl;
    burst_interleave = bt;
    cas_lat_code     = cl;
    drive_half       = hf;
    rst = 1'b0;
    for (int n = 1; n <= LAST; n++) begin
      @(negedge clk);
      check(tag_of(n), n, got_bus(), exp_bus(n, bl, bt, cl, hf));
      if (n == abort_at) break;
    end
    rst = 1'b1;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      check("R11", k, got_bus(), exp_bus(0, bl, bt, cl, hf));
    end
  endtask

  function automatic logic [2:0] pick_cl(int i);
    case (i)
      0: return 3'b010;
      1: return 3'b011;
      default: return 3'b110;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    check("R1", 0, got_bus(), exp_bus(0, 3'd1, 1'b0, 3'd2, 1'b0));
    // Directed corner runs: opposite field settings.
    do_run(3'b001, 1'b0, 3'b010, 1'b0, -1);
    do_run(3'b011, 1'b1, 3'b110, 1'b1, -1);
    // Reset during the settling wait, then inside the DLL hold (R11).
    do_run(3'b010, 1'b0, 3'b011, 1'b1, 5);
    do_run(3'b010, 1'b1, 3'b011, 1'b0, C2 + 50);
    do_run(3'b010, 1'b1, 3'b011, 1'b0, -1);
    for (int r = 0; r < 10; r++) begin
      logic [2:0] bl, cl;
      logic bt, hf;
      int ab;
      bl = 3'($urandom_range(1, 3));
      cl = pick_cl(int'($urandom_range(0, 2)));
      bt = 1'($urandom_range(0, 1));
      hf = 1'($urandom_range(0, 1));
      ab = ($urandom_range(0, 1) == 1) ? int'($urandom_range(1, LAST - 1)) : -1;
      do_run(bl, bt, cl, hf, ab);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule